// File: doc/BRIEF.md
# Configurable Bidirectional I/O Port

This block is an 8-bit general-purpose I/O port that sits on a simple synchronous register bus. Software sets each pin through two bits: a direction bit in the configuration register and a value bit in the output register. From these two bits the pin becomes one of four things: a floating input, an input with a weak pull-up, an output driving low, or an output driving high. For every pin the block drives an output-enable, an output value and a pull-up enable toward the pad ring. It brings the pad levels back through a two-flop synchronizer, and software reads them from a read-only snapshot address.

A parameter picks one of three kinds of port. A plain bidirectional port resets to all inputs. A control port is the same, except that two bits of its output register are write-only power requests: each write of a 1 to them gives a single-cycle pulse. Two of its configuration bits are also brought out as clock-option controls. An output-only port drives every pin at all times and holds all outputs high while reset is asserted.

Top module: `gpio_cfg_port`

## Requirements
- R1: A pin whose configuration bit is 0 and data bit is 0 is a floating input: pin_oe, pin_out and pin_pu are all 0 for that pin.
- R2: A pin whose configuration bit is 0 and data bit is 1 is an input with pull-up: pin_pu is 1, while pin_oe and pin_out are 0.
- R3: A pin whose configuration bit is 1 and data bit is 0 drives low: pin_oe is 1, and pin_out and pin_pu are 0.
- R4: A pin whose configuration bit is 1 and data bit is 1 drives high: pin_oe and pin_out are 1 and pin_pu is 0.
- R5: The register addresses are 0 for configuration (read/write), 1 for output data (read/write) and 2 for the pin snapshot (read-only; writes there change nothing). bus_rdata follows bus_addr combinationally, and a write takes effect at the clock edge where bus_wr is high.
- R6: A read of address 2 returns pin_in as it was sampled two rising clock edges earlier.
- R7: After reset the configuration and data registers of a bidirectional or control port read 0, every pin is a floating input, and halt_req and idle_req are 0.
- R8: A write to address 3 changes no register and no output, and a read of address 3 returns 0.
- R9: On a control port, writing address 1 with bit 7 set raises halt_req, and with bit 6 set raises idle_req. Each is high for exactly the one cycle after the write edge. These two data bits are never stored: they read back 0 and act as 0 in the pin decode.
- R10: On a control port, configuration bit 6 drives alt_sck_phase and configuration bit 7 drives wake_dly_en, and both bits still set the mode of pins 6 and 7.
- R11: On an output-only port, pin_oe and pin_out are all ones while reset is asserted. pin_oe stays all ones and pin_pu stays 0 at all times, pin_out follows the data register, and address 0 ignores writes and reads 0.
- R12: On a port that is not a control port, halt_req, idle_req, alt_sck_phase and wake_dly_en stay 0 whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for bus_addr |
| pin_in | input | W | Pad input levels |
| pin_oe | output | W | Per-pin output enable |
| pin_out | output | W | Per-pin driven value |
| pin_pu | output | W | Per-pin weak pull-up enable |
| halt_req | output | 1 | Single-cycle halt request pulse |
| idle_req | output | 1 | Single-cycle idle request pulse |
| alt_sck_phase | output | 1 | Alternate serial clock phase select |
| wake_dly_en | output | 1 | Clock start-up delay enable after halt |

## Verification
The bench builds two copies with W = 8 and two synchronizer stages. The first is a control port, so the four-mode decode, the write-only power bits and their pulses, and the configuration bits brought out as clock options can all be checked. The second is an output-only port, which brings in the preset-high outputs during reset, the configuration address that ignores writes, and the control outputs that must stay quiet. The plain bidirectional kind shares its register and decode path with the control port, and differs from it only in the stored power bits.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    PORT_BIDIR   = 2'd0,
    PORT_CTRL    = 2'd1,
    PORT_OUTONLY = 2'd2
  } port_kind_e;

  // pin mode, encoded as {direction bit, value bit}
  typedef enum logic [1:0] {
    PM_FLOAT  = 2'b00,
    PM_PULLUP = 2'b01,
    PM_DRIVE0 = 2'b10,
    PM_DRIVE1 = 2'b11
  } pin_mode_e;

  localparam int unsigned REG_AW = 2;
  localparam logic [REG_AW-1:0] A_CFG  = 2'd0;
  localparam logic [REG_AW-1:0] A_DATA = 2'd1;
  localparam logic [REG_AW-1:0] A_PIN  = 2'd2;

  // control-port bit positions
  localparam int unsigned HALT_BIT = 7;
  localparam int unsigned IDLE_BIT = 6;
  localparam int unsigned SCK_BIT  = 6;
  localparam int unsigned WDLY_BIT = 7;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= 2'b00;
    else        shift_q <= {shift_q[0], 1'b1};
  end

  assign rst_core_n = shift_q[1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = d;
    end else begin : g_next
      assign stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned W    = 8,
  parameter port_kind_e  KIND = PORT_CTRL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [REG_AW-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      cfg_q,
  output logic [W-1:0]      data_q,
  output logic              halt_q,
  output logic              idle_q
);
  localparam bit IS_CTRL = (KIND == PORT_CTRL);
  localparam bit IS_OUT  = (KIND == PORT_OUTONLY);
  localparam logic [W-1:0] PWR_MASK =
    IS_CTRL ? ((W'(1) << HALT_BIT) | (W'(1) << IDLE_BIT)) : '0;
  localparam logic [W-1:0] CFG_RST  = IS_OUT ? {W{1'b1}} : '0;
  localparam logic [W-1:0] DATA_RST = IS_OUT ? {W{1'b1}} : '0;

  logic         cfg_we, data_we;
  logic [W-1:0] cfg_d, data_d;
  logic         halt_d, idle_d;

  always_comb begin
    cfg_we  = wr && (addr == A_CFG) && !IS_OUT;
    data_we = wr && (addr == A_DATA);
    cfg_d   = wdata;
    data_d  = wdata & ~PWR_MASK;
    halt_d  = 1'b0;
    idle_d  = 1'b0;
    if (IS_CTRL && data_we) begin
      halt_d = wdata[HALT_BIT];
      idle_d = wdata[IDLE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RST;
      data_q <= DATA_RST;
      halt_q <= 1'b0;
      idle_q <= 1'b0;
    end else begin
      if (cfg_we)  cfg_q  <= cfg_d;
      if (data_we) data_q <= data_d;
      halt_q <= halt_d;
      idle_q <= idle_d;
    end
  end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] cfg,
  input  logic [W-1:0] data,
  output logic [W-1:0] oe,
  output logic [W-1:0] out,
  output logic [W-1:0] pu
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    pin_mode_e mode;
    assign mode = pin_mode_e'({cfg[i], data[i]});
    always_comb begin
      oe[i]  = 1'b0;
      out[i] = 1'b0;
      pu[i]  = 1'b0;
      unique case (mode)
        PM_FLOAT:  ;
        PM_PULLUP: pu[i] = 1'b1;
        PM_DRIVE0: oe[i] = 1'b1;
        PM_DRIVE1: begin
          oe[i]  = 1'b1;
          out[i] = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_cfg_port.sv
module gpio_cfg_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter port_kind_e  KIND        = PORT_CTRL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_oe,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_pu,
  output logic              halt_req,
  output logic              idle_req,
  output logic              alt_sck_phase,
  output logic              wake_dly_en
);
  logic         rst_core_n;
  logic [W-1:0] cfg_q, data_q, pin_sync;
  logic         halt_q, idle_q;

  gpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  gpio_port_regs #(.W(W), .KIND(KIND)) u_regs (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .wr     (bus_wr),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .cfg_q  (cfg_q),
    .data_q (data_q),
    .halt_q (halt_q),
    .idle_q (idle_q)
  );

  gpio_pad_ctrl #(.W(W)) u_pad (
    .cfg  (cfg_q),
    .data (data_q),
    .oe   (pin_oe),
    .out  (pin_out),
    .pu   (pin_pu)
  );

  gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     (pin_in),
    .q     (pin_sync)
  );

  always_comb begin
    unique case (bus_addr)
      A_CFG:   bus_rdata = (KIND == PORT_OUTONLY) ? '0 : cfg_q;
      A_DATA:  bus_rdata = data_q;
      A_PIN:   bus_rdata = pin_sync;
      default: bus_rdata = '0;
    endcase
  end

  if (KIND == PORT_CTRL) begin : g_ctrl
    assign halt_req      = halt_q;
    assign idle_req      = idle_q;
    assign alt_sck_phase = cfg_q[SCK_BIT];
    assign wake_dly_en   = cfg_q[WDLY_BIT];
  end else begin : g_plain
    logic unused_pwr;
    assign unused_pwr    = halt_q ^ idle_q;
    assign halt_req      = 1'b0;
    assign idle_req      = 1'b0;
    assign alt_sck_phase = 1'b0;
    assign wake_dly_en   = 1'b0;
  end
endmodule

// File: rtl/gpio_cfg_port_chk.sv
module gpio_cfg_port_chk
  import gpio_port_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              bus_wr,
  input logic [REG_AW-1:0] bus_addr,
  input logic              wd_halt,
  input logic              wd_idle,
  input logic [W-1:0]      bus_rdata,
  input logic [W-1:0]      pin_in,
  input logic [W-1:0]      pin_oe,
  input logic [W-1:0]      pin_out,
  input logic [W-1:0]      pin_pu,
  input logic              halt_req,
  input logic              idle_req
);
  logic [1:0] warm_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)          warm_q <= 2'd0;
    else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
  end

  // R2
  pu_not_driving_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (pin_pu & pin_oe) == '0);

  // R3
  out_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (pin_out & ~pin_oe) == '0);

  // R5
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(bus_wr && bus_addr == A_CFG) |=> $stable(pin_oe));

  // R8
  unused_read_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_addr == 2'd3) |-> (bus_rdata == '0));

  // R9
  halt_cause_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    halt_req |-> ($past(bus_wr) && $past(bus_addr) == A_DATA && $past(wd_halt)));

  // R9
  idle_cause_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    idle_req |-> ($past(bus_wr) && $past(bus_addr) == A_DATA && $past(wd_idle)));

  if (SYNC_STAGES == 2) begin : g_lat
    // R6
    pin_latency_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
      (warm_q == 2'd2 && bus_addr == A_PIN) |-> (bus_rdata == $past(pin_in, 2)));
  end
endmodule

bind gpio_cfg_port gpio_cfg_port_chk #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .wd_halt    (bus_wdata[gpio_port_pkg::HALT_BIT]),
  .wd_idle    (bus_wdata[gpio_port_pkg::IDLE_BIT]),
  .bus_rdata  (bus_rdata),
  .pin_in     (pin_in),
  .pin_oe     (pin_oe),
  .pin_out    (pin_out),
  .pin_pu     (pin_pu),
  .halt_req   (halt_req),
  .idle_req   (idle_req)
);

// File: tb/gpio_cfg_port_tb.sv
`timescale 1ns/100ps
module gpio_cfg_port_tb;
  import gpio_port_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_c, wr_o;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] pin_c, pin_o;
  logic [7:0] rd_c, oe_c, out_c, pu_c;
  logic [7:0] rd_o, oe_o, out_o, pu_o;
  logic       halt_c, idle_c, sck_c, wdly_c;
  logic       halt_o, idle_o, sck_o, wdly_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  gpio_cfg_port #(.W(8), .SYNC_STAGES(2), .KIND(PORT_CTRL)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr_c), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rd_c), .pin_in(pin_c), .pin_oe(oe_c), .pin_out(out_c), .pin_pu(pu_c),
    .halt_req(halt_c), .idle_req(idle_c), .alt_sck_phase(sck_c), .wake_dly_en(wdly_c)
  );

  gpio_cfg_port #(.W(8), .SYNC_STAGES(2), .KIND(PORT_OUTONLY)) u_out (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr_o), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rd_o), .pin_in(pin_o), .pin_oe(oe_o), .pin_out(out_o), .pin_pu(pu_o),
    .halt_req(halt_o), .idle_req(idle_o), .alt_sck_phase(sck_o), .wake_dly_en(wdly_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one write cycle; returns at the falling edge just after the write edge
  task automatic bus_write(input bit to_out, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (to_out) wr_o = 1'b1; else wr_c = 1'b1;
    @(negedge clk);
    wr_c = 1'b0; wr_o = 1'b0;
  endtask

  task automatic bus_read(input bit from_out, input logic [1:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = from_out ? rd_o : rd_c;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R11", "out-only oe in reset", oe_o, 8'hFF);
    check("R11", "out-only out in reset", out_o, 8'hFF);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R7", "oe after reset", oe_c, 8'h00);
    check("R7", "out after reset", out_c, 8'h00);
    check("R7", "pu after reset", pu_c, 8'h00);
    check("R7", "halt/idle after reset", {halt_c, idle_c}, 2'b00);
    bus_read(0, A_CFG, v);  check("R7", "cfg read", v, 8'h00);
    bus_read(0, A_DATA, v); check("R7", "data read", v, 8'h00);
  endtask

  task automatic t_modes();
    // pins: 0 float, 1 pull-up, 2 drive low, 3 drive high
    bus_write(0, A_CFG, 8'h0C);
    bus_write(0, A_DATA, 8'h0A);
    check("R1", "pin0 {oe,out,pu}", {oe_c[0], out_c[0], pu_c[0]}, 3'b000);
    check("R2", "pin1 {oe,out,pu}", {oe_c[1], out_c[1], pu_c[1]}, 3'b001);
    check("R3", "pin2 {oe,out,pu}", {oe_c[2], out_c[2], pu_c[2]}, 3'b100);
    check("R4", "pin3 {oe,out,pu}", {oe_c[3], out_c[3], pu_c[3]}, 3'b110);
    bus_write(0, A_CFG, 8'h33);
    bus_write(0, A_DATA, 8'h25);
    check("R4", "pattern2 oe", oe_c, 8'h33);
    check("R4", "pattern2 out", out_c, 8'h21);
    check("R2", "pattern2 pu", pu_c, 8'h04);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    bus_read(0, A_CFG, v);  check("R5", "cfg readback", v, 8'h33);
    bus_read(0, A_DATA, v); check("R5", "data readback", v, 8'h25);
    bus_write(0, A_PIN, 8'hFF);
    bus_read(0, A_CFG, v);  check("R5", "cfg after pin write", v, 8'h33);
    bus_read(0, A_DATA, v); check("R5", "data after pin write", v, 8'h25);
    check("R5", "oe after pin write", oe_c, 8'h33);
  endtask

  task automatic t_unused();
    logic [7:0] v;
    bus_write(0, 2'd3, 8'hFF);
    bus_read(0, 2'd3, v);   check("R8", "unused read", v, 8'h00);
    check("R8", "oe after unused write", oe_c, 8'h33);
    check("R8", "out after unused write", out_c, 8'h21);
    check("R8", "pu after unused write", pu_c, 8'h04);
  endtask

  task automatic t_pin();
    logic [7:0] v;
    @(negedge clk);
    pin_c = 8'hA5;
    bus_read(0, A_PIN, v);  check("R6", "pin read, no edge yet", v, 8'h00);
    @(negedge clk);
    bus_read(0, A_PIN, v);  check("R6", "pin read, one edge", v, 8'h00);
    @(negedge clk);
    bus_read(0, A_PIN, v);  check("R6", "pin read, two edges", v, 8'hA5);
    pin_c = 8'h5A;
    @(negedge clk);
    bus_read(0, A_PIN, v);  check("R6", "pin read, one edge", v, 8'hA5);
    @(negedge clk);
    bus_read(0, A_PIN, v);  check("R6", "pin read, two edges", v, 8'h5A);
  endtask

  task automatic t_power();
    logic [7:0] v;
    bus_write(0, A_DATA, 8'hA5);
    check("R9", "halt pulse", {halt_c, idle_c}, 2'b10);
    @(negedge clk);
    check("R9", "halt pulse ends", {halt_c, idle_c}, 2'b00);
    bus_read(0, A_DATA, v); check("R9", "power bits not stored", v, 8'h25);
    check("R9", "out unchanged", out_c, 8'h21);
    bus_write(0, A_DATA, 8'h40);
    check("R9", "idle pulse", {halt_c, idle_c}, 2'b01);
    bus_write(0, A_DATA, 8'hC0);
    check("R9", "both pulses", {halt_c, idle_c}, 2'b11);
    @(negedge clk);
    check("R9", "both pulses end", {halt_c, idle_c}, 2'b00);
    bus_read(0, A_DATA, v); check("R9", "data reads zero", v, 8'h00);
  endtask

  task automatic t_ctrlcfg();
    bus_write(0, A_CFG, 8'hC0);
    check("R10", "sck/wdly", {sck_c, wdly_c}, 2'b11);
    check("R10", "pins 7:6 drive", oe_c, 8'hC0);
    bus_write(0, A_CFG, 8'h40);
    check("R10", "sck only", {sck_c, wdly_c}, 2'b10);
  endtask

  task automatic t_outonly();
    logic [7:0] v;
    bus_write(1, A_DATA, 8'h3C);
    check("R11", "out-only out", out_o, 8'h3C);
    check("R11", "out-only oe", oe_o, 8'hFF);
    check("R11", "out-only pu", pu_o, 8'h00);
    bus_write(1, A_CFG, 8'h00);
    check("R11", "oe after cfg write", oe_o, 8'hFF);
    bus_read(1, A_CFG, v);  check("R11", "cfg reads zero", v, 8'h00);
    bus_write(1, A_DATA, 8'hC0);
    check("R12", "no pulses", {halt_o, idle_o}, 2'b00);
    check("R11", "out-only high bits", out_o, 8'hC0);
    @(negedge clk);
    check("R12", "clock options quiet", {sck_o, wdly_o, halt_o, idle_o}, 4'b0000);
  endtask

  initial begin
    wr_c = 1'b0; wr_o = 1'b0; addr = 2'd0; wdata = 8'h00;
    pin_c = 8'h00; pin_o = 8'h00;
    t_reset();
    t_modes();
    t_regs();
    t_unused();
    t_pin();
    t_power();
    t_ctrlcfg();
    t_outonly();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule